// File: doc/BRIEF.md
# Bus-Master DMA Register Window for a Two-Channel Disk Controller

This block is the I/O register window that software uses to program the bus-master DMA engines of a two-channel disk controller. The window is 16 bytes long. Address bit 3 selects a channel, and each channel owns an 8-byte slice. A slice holds a command byte, a status byte and a 32-bit pointer to the descriptor table. The rest of the slice is unused.

Accesses arrive on a simple register bus that carries an address, a size code, a write strobe and write data. Read data is combinational from the address and the size. For each channel the block drives a start bit, a transfer-direction bit and the aligned table pointer to the DMA engine. From the engine it takes an activity level, an error indication and an interrupt line for each channel, and it folds these into the status byte.

The command and status bytes answer only to single-byte accesses. A wider access to the first four bytes of a slice reads as all ones, and its write data is dropped. The table pointer accepts byte, word and dword accesses.

Top module: `bmdma_window`

## Requirements
- R1: After a synchronous active-low reset, for both channels: start, direction, error, interrupt, both flag bits and the table pointer are all zero.
- R2: `bus_addr[3]` selects the channel. The offset within the slice is `bus_addr[2:0]`: offset 0 is command, offset 2 is status, offsets 4 to 7 are the table pointer.
- R3: A byte write to command sets start from data bit 0 and direction from data bit 3. These bits drive `ch_start` and `ch_to_mem` on the next cycle. A command read returns those two bits in the same positions, and all other bits read 0.
- R4: The size code is 0 for byte, 1 for word, and 2 or 3 for dword. A read at offsets 0 to 3 whose size is not byte returns 0xFFFF for word and 0xFFFFFFFF for dword. For every read, the `bus_rdata` bits above the access width are 0.
- R5: A write at offsets 0 to 3 whose size is not byte changes no command or status bit.
- R6: A byte read at offset 1 or 3 returns 0xFF. A byte write at offset 1 or 3 changes nothing.
- R7: Status layout: bit 0 is the live `dma_active` level of the channel, bit 1 is error, bit 2 is interrupt, and bits 5 and 6 are read/write flags. Bits 3, 4 and 7 read 0.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged. Bits 5 and 6 take the written value.
- R9: A rising edge of `dma_irq` sets the interrupt bit, and a level that stays high does not set it again after a clear. A high `dma_err` sets the error bit. In the same cycle, a set wins over a write-1 clear.
- R10: A table-pointer write of n bytes (n = 1, 2 or 4) at offset 4+k stores data byte i into pointer byte k+i. Bytes beyond pointer byte 3 are dropped. Pointer bits 1:0 are always 0.
- R11: A table-pointer read at offset 4+k returns the pointer shifted right by 8*k bits, masked to the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address within the window |
| bus_size | input | 2 | Access size code: 0 byte, 1 word, 2 or 3 dword |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data, byte lane 0 at the addressed byte |
| bus_rdata | output | 32 | Combinational read data for the current address and size |
| dma_active | input | 2 | Engine busy level, one bit per channel |
| dma_err | input | 2 | Engine error indication, one bit per channel |
| dma_irq | input | 2 | Drive interrupt line, one bit per channel |
| ch_start | output | 2 | Start bit of each channel |
| ch_to_mem | output | 2 | Direction bit of each channel |
| ch_tbl_addr | output | 64 | Table pointer of each channel, channel 0 in bits 31:0 |

## Verification
The hardest situations to reach from the ports involve timing on the status byte. One is a write-1 clear that lands in the same cycle as a new interrupt edge. Another is an interrupt line held high across a clear, where the bit must stay cleared.

Directed sequences build both situations cycle by cycle. Long random runs then toggle `dma_irq` and `dma_err` independently of a stream of mixed-size writes and reads, so these collisions also occur at random. A bench model tracks the previous interrupt level for each channel and predicts every status, command and pointer value.

Misaligned pointer writes that run past the last byte are aimed at directly and also occur in the random stream.

// File: rtl/bmdma_pkg.sv
// Package bmdma_pkg
// Purpose: shared access-size codes and byte-width helpers for the DMA window.
// Assumes: size code 2'b1x always means a dword access.
package bmdma_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DW_R  = 2'd3
    } acc_size_e;

    // Number of bytes that an access of this size carries.
    function automatic int size_bytes(input logic [1:0] sz);
        if (sz == SZ_BYTE) return 1;
        if (sz == SZ_WORD) return 2;
        return 4;
    endfunction

    // Mask that keeps only the bits inside the access width.
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        if (sz == SZ_BYTE) return 32'h0000_00FF;
        if (sz == SZ_WORD) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction
endpackage

// File: rtl/bmdma_decode.sv
// Module bmdma_decode
// Purpose: split a window address into a channel index and a slice offset,
//          and steer the write strobe to the selected channel only.
// Assumes: NCH is a power of two and at least 2; each slice is 8 bytes.
module bmdma_decode #(
    parameter int NCH = 2,
    localparam int SEL_W = $clog2(NCH),
    localparam int ADDR_W = SEL_W + 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [SEL_W-1:0]  ch_sel,
    output logic [2:0]        offset,
    output logic [NCH-1:0]    ch_wr
);
    // Split the address into channel number and offset within the slice.
    always_comb begin
        ch_sel = addr[ADDR_W-1:3];
        offset = addr[2:0];
    end

    // Give the write strobe to the selected channel slice only.
    always_comb begin
        ch_wr = '0;
        ch_wr[ch_sel] = wr;
    end
endmodule

// File: rtl/bmdma_chan.sv
// Module bmdma_chan
// Purpose: command, status and table-pointer registers of one DMA channel,
//          plus its unmasked read data.
// Assumes: wr is already qualified for this channel; the caller masks the
//          read data to the access width.
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [2:0]  offset,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic        active,
    input  logic        err_in,
    input  logic        irq_in,
    output logic [31:0] rdata,
    output logic        start,
    output logic        to_mem,
    output logic [31:0] tbl_addr
);
    logic       err_q, irq_q, flag5_q, flag6_q, irq_d1;
    logic       is_byte, cmd_wr, sts_wr, ptr_wr, irq_rise;
    logic [31:0] tbl_next;
    logic [7:0] cmd_byte, sts_byte;

    // Decode which register this write targets.
    always_comb begin
        is_byte  = (size == SZ_BYTE);
        cmd_wr   = wr && is_byte && (offset == 3'd0);
        sts_wr   = wr && is_byte && (offset == 3'd2);
        ptr_wr   = wr && offset[2];
        irq_rise = irq_in && !irq_d1;
    end

    // Merge the written lanes into the table pointer and keep it dword-aligned.
    always_comb begin
        tbl_next = tbl_addr;
        if (ptr_wr) begin
            for (int i = 0; i < 4; i++) begin
                if (i < size_bytes(size) && (int'(offset[1:0]) + i) < 4)
                    tbl_next[(int'(offset[1:0]) + i)*8 +: 8] = wdata[i*8 +: 8];
            end
        end
        tbl_next[1:0] = 2'b00;
    end

    // Command register: start and direction bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start  <= 1'b0;
            to_mem <= 1'b0;
        end else if (cmd_wr) begin
            start  <= wdata[0];
            to_mem <= wdata[3];
        end
    end

    // Status register: sticky error and interrupt bits (set wins over clear), plus two plain flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            flag5_q <= 1'b0;
            flag6_q <= 1'b0;
        end else begin
            err_q <= (err_q && !(sts_wr && wdata[1])) || err_in;
            irq_q <= (irq_q && !(sts_wr && wdata[2])) || irq_rise;
            if (sts_wr) begin
                flag5_q <= wdata[5];
                flag6_q <= wdata[6];
            end
        end
    end

    // Remember the last interrupt level for edge detection, and store the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_d1   <= 1'b0;
            tbl_addr <= '0;
        end else begin
            irq_d1   <= irq_in;
            tbl_addr <= tbl_next;
        end
    end

    // Build the read data for the addressed offset.
    always_comb begin
        cmd_byte = {4'b0, to_mem, 2'b0, start};
        sts_byte = {1'b0, flag6_q, flag5_q, 2'b0, irq_q, err_q, active};
        if (offset[2])
            rdata = tbl_addr >> {offset[1:0], 3'b000};
        else if (!is_byte)
            rdata = 32'hFFFF_FFFF;
        else if (offset[1:0] == 2'd0)
            rdata = {24'b0, cmd_byte};
        else if (offset[1:0] == 2'd2)
            rdata = {24'b0, sts_byte};
        else
            rdata = 32'h0000_00FF;
    end

    // R5
    wide_wr_keeps_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !offset[2] && !is_byte) |=> ($stable(start) && $stable(to_mem)));
    // R9
    irq_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in && !irq_d1) |=> irq_q);
    // R8
    w1c_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && wdata[2] && !(irq_in && !irq_d1)) |=> !irq_q);
    // R3
    cmd_write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (start == $past(wdata[0])));
    // R10
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (tbl_addr[1:0] == 2'b00));
endmodule

// File: rtl/bmdma_window.sv
// Module bmdma_window
// Purpose: top of the bus-master DMA register window. It decodes the window,
//          builds one register slice per channel and returns the read data
//          masked to the access width.
// Assumes: read data is combinational; a write takes effect at the next clock edge.
module bmdma_window
    import bmdma_pkg::*;
#(
    parameter int NCH = 2,
    localparam int SEL_W = $clog2(NCH),
    localparam int ADDR_W = SEL_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    dma_active,
    input  logic [NCH-1:0]    dma_err,
    input  logic [NCH-1:0]    dma_irq,
    output logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_to_mem,
    output logic [NCH*32-1:0] ch_tbl_addr
);
    logic [SEL_W-1:0] ch_sel;
    logic [2:0]       offset;
    logic [NCH-1:0]   ch_wr;
    logic [31:0]      ch_rdata [NCH];

    bmdma_decode #(.NCH(NCH)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .ch_sel(ch_sel),
        .offset(offset), .ch_wr(ch_wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmdma_chan u_chan (
            .clk(clk), .rst_n(rst_n), .wr(ch_wr[c]), .offset(offset),
            .size(bus_size), .wdata(bus_wdata), .active(dma_active[c]),
            .err_in(dma_err[c]), .irq_in(dma_irq[c]), .rdata(ch_rdata[c]),
            .start(ch_start[c]), .to_mem(ch_to_mem[c]),
            .tbl_addr(ch_tbl_addr[c*32 +: 32])
        );
    end

    // Select the channel's read data and keep only the access width.
    always_comb bus_rdata = ch_rdata[ch_sel] & size_mask(bus_size);

    // R4
    wide_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size != SZ_BYTE && !bus_addr[2]) |-> (bus_rdata == size_mask(bus_size)));
    // R2
    other_chan_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1:3] == '0) |=> $stable(ch_tbl_addr[NCH*32-1:32]));
endmodule

// File: tb/sim_bmdma_window.sv
module sim_bmdma_window;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  dma_active = '0, dma_err = '0, dma_irq = '0;
    logic [1:0]  ch_start, ch_to_mem;
    logic [63:0] ch_tbl_addr;

    int n_chk = 0, n_err = 0;

    // bench model
    logic        m_start[2], m_dir[2], m_err[2], m_irq[2], m_f5[2], m_f6[2], m_prev[2];
    logic [31:0] m_ptr[2];

    bmdma_window u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    initial begin
        #(CLK_P*200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    function automatic logic [31:0] wmask(input logic [1:0] sz);
        return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
        int c = a[3];
        logic [2:0] o = a[2:0];
        logic [31:0] v;
        if (o[2]) v = m_ptr[c] >> (8*o[1:0]);
        else if (sz != 0) v = 32'hFFFF_FFFF;
        else if (o == 0) v = {24'b0, 4'b0, m_dir[c], 2'b0, m_start[c]};
        else if (o == 2) v = {24'b0, 1'b0, m_f6[c], m_f5[c], 2'b0, m_irq[c], m_err[c], dma_active[c]};
        else v = 32'hFF;
        return v & wmask(sz);
    endfunction

    function automatic string tag(input logic [3:0] a, input logic [1:0] sz);
        if (a[2]) return "R11";
        if (sz != 0) return "R4";
        if (a[0]) return "R6";
        if (a[1]) return "R7";
        return "R3";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mreset();
        for (int c = 0; c < 2; c++) begin
            m_start[c] = 0; m_dir[c] = 0; m_err[c] = 0; m_irq[c] = 0;
            m_f5[c] = 0; m_f6[c] = 0; m_prev[c] = 0; m_ptr[c] = 0;
        end
    endtask

    // One clock step: drive at the falling edge, then update the model after the rising edge.
    task automatic step(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic [1:0] act,
                        input logic [1:0] er, input logic [1:0] iq);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        dma_active = act; dma_err = er; dma_irq = iq;
        @(posedge clk);
        #1;
        if (wr) begin
            int c = a[3];
            if (a[2]) begin
                for (int i = 0; i < 4; i++) begin
                    int b = int'(a[1:0]) + i;
                    if (i < (sz == 0 ? 1 : sz == 1 ? 2 : 4) && b < 4)
                        m_ptr[c][b*8 +: 8] = d[i*8 +: 8];
                end
                m_ptr[c][1:0] = 0;
            end else if (sz == 0 && a[1:0] == 0) begin
                m_start[c] = d[0]; m_dir[c] = d[3];
            end else if (sz == 0 && a[1:0] == 2) begin
                if (d[1]) m_err[c] = 0;
                if (d[2]) m_irq[c] = 0;
                m_f5[c] = d[5]; m_f6[c] = d[6];
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (er[c]) m_err[c] = 1;
            if (iq[c] && !m_prev[c]) m_irq[c] = 1;
            m_prev[c] = iq[c];
        end
        bus_wr = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [1:0] sz);
        bus_addr = a; bus_size = sz;
        #1;
        chk(req, bus_rdata, exp_read(a, sz));
    endtask

    task automatic outs();
        chk("R3", {30'b0, ch_start}, {30'b0, m_start[1], m_start[0]});
        chk("R3", {30'b0, ch_to_mem}, {30'b0, m_dir[1], m_dir[0]});
        chk("R10", ch_tbl_addr[31:0], m_ptr[0]);
        chk("R10", ch_tbl_addr[63:32], m_ptr[1]);
    endtask

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        mreset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        for (int a = 0; a < 16; a++) rd("R1", 4'(a), 0);
        outs();

        // R3 command both bits, other bits ignored
        step(1, 4'h0, 0, 32'hFF, 0, 0, 0); rd("R3", 4'h0, 0); outs();
        // R5 wide writes at command/status ignored
        step(1, 4'h8, 1, 32'h0909, 0, 0, 0); rd("R5", 4'h8, 0);
        step(1, 4'h0, 2, 32'h0, 0, 0, 0); rd("R5", 4'h0, 0);
        // R4 wide reads
        rd("R4", 4'h0, 1); rd("R4", 4'hA, 2); rd("R4", 4'h2, 3);
        // R6 reserved bytes
        step(1, 4'h1, 0, 32'h0, 0, 0, 0); rd("R6", 4'h1, 0); rd("R6", 4'hB, 0); outs();
        // R7 status flags and active level
        step(1, 4'hA, 0, 32'hFF, 2'b10, 0, 0); rd("R7", 4'hA, 0);
        // R9 irq edge, held level, clear, no re-set; set wins against clear
        step(0, 4'h2, 0, 0, 0, 0, 2'b01); rd("R9", 4'h2, 0);
        step(1, 4'h2, 0, 32'h04, 0, 0, 2'b01); rd("R8", 4'h2, 0);
        step(0, 4'h2, 0, 0, 0, 0, 2'b01); rd("R9", 4'h2, 0);
        step(0, 4'h2, 0, 0, 0, 0, 2'b00);
        step(1, 4'h2, 0, 32'h06, 0, 2'b01, 2'b01); rd("R9", 4'h2, 0);
        step(1, 4'h2, 0, 32'h00, 0, 0, 2'b01); rd("R8", 4'h2, 0);
        // R10 pointer alignment and overrun
        step(1, 4'h4, 2, 32'h1234_5677, 0, 0, 0); rd("R10", 4'h4, 2);
        step(1, 4'h7, 1, 32'hABCD, 0, 0, 0); rd("R10", 4'h4, 2); rd("R11", 4'h6, 1);
        step(1, 4'hC, 0, 32'h0000_00FF, 0, 0, 0); rd("R10", 4'hC, 2);
        step(1, 4'hD, 2, 32'hCAFE_BEEF, 0, 0, 0); rd("R11", 4'hD, 2); outs();

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] a = 4'($urandom_range(0, 15));
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic [3:0] ra = 4'($urandom_range(0, 15));
            logic [1:0] rs = 2'($urandom_range(0, 3));
            step(1'($urandom_range(0, 1)), a, sz, $urandom,
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3) == 0 ? 1 : 0),
                 2'($urandom_range(0, 3)));
            rd(tag(ra, rs), ra, rs);
            if (n % 16 == 0) outs();
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule